// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block produces the six gate timing signals for a phase-shifted full-bridge converter with synchronous rectification. One bridge leg (the leading leg) is driven by a complementary pair `lead_p` / `lead_n`. The other leg (the lagging leg) is driven by `lag_p` / `lag_n`. Two rectifier gates, `rect_p` and `rect_n`, drive the secondary side. Both legs switch with a fixed half-period of `HALF_STEPS` steps. Power transfer is set by how far the lagging leg trails the leading leg, not by modulating pulse width.

Time advances only on clocks where `step` is high, so an external oscillator tick sets the switching rate. One switching period spans two half-cycles: the first belongs to `lead_p`, the second to `lead_n`. Dead times, the lag offset and the rectifier turn-off delay arrive as digital counts. They are clamped to safe values and captured at the first step of every half-cycle. Dropping `en` forces every gate low at the next clock. The sequence then starts again from the `lead_p` half.

Top module: `psfb_gate_seq`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge on which `en` is sampled low, all six outputs are low and the position returns to the start. After `en` rises, the first half-cycle is the `lead_p` half, so `lead_p` is the first primary output to assert.
- R2: Position advances one step per clock with `step` high and holds otherwise, with all outputs unchanged. A full period is 2*HALF_STEPS steps, and `lead_p` rises exactly once per period under constant settings.
- R3: Let `lead_dead` be `dead_ab` clamped to 1..HALF_STEPS-1 (0 becomes 1). `lead_p` may be high only in its half, from step index `lead_dead` to the last step. `lead_n` behaves the same way in the other half. The two are never high together, and each is low for at least one step before it rises.
- R4: Let the lag dead time be `dead_cd` clamped to 1..HALF_STEPS-1, and let the lag offset be `phase_cmd` limited to HALF_STEPS-1 minus that dead time. In the `lead_p` half, `lag_n` falls at step index offset and `lag_p` rises at offset plus dead time. In the `lead_n` half the roles swap. The pair never overlaps.
- R5: All four setting inputs are captured only at step index 0 of each half-cycle. Changes at any other time have no effect until the next half begins.
- R6: `rect_p` rises in the same step as `lag_p`, and `rect_n` in the same step as `lag_n`.
- R7: `rect_p` falls at step index d of the `lead_p` half, which is d steps after `lead_n` fell. `rect_n` falls at step index d of the `lead_n` half. Here d is `sr_delay` limited to (offset + lag dead time - 1), so each rectifier is always low before it rises again.
- R8: In any step where `rect_p` and `rect_n` are both high, `lead_p` and `lead_n` are held low.
- R9: Under constant settings, `lead_n` rises exactly HALF_STEPS steps after `lead_p` rises, giving equal half-periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates low |
| step | input | 1 | Oscillator tick; advances the sequence by one step |
| phase_cmd | input | CW | Lag of the lagging leg behind the leading leg, in steps |
| dead_ab | input | CW | Leading-leg dead time in steps |
| dead_cd | input | CW | Lagging-leg dead time in steps |
| sr_delay | input | CW | Delay from a leading-leg fall to the matching rectifier fall |
| lead_p | output | 1 | Leading leg, first-half switch |
| lead_n | output | 1 | Leading leg, second-half switch |
| lag_p | output | 1 | Lagging leg, switch turned on in the first half |
| lag_n | output | 1 | Lagging leg, switch turned on in the second half |
| rect_p | output | 1 | Rectifier gate paired with `lag_p` |
| rect_n | output | 1 | Rectifier gate paired with `lag_n` |

## Verification
The bench drives zero dead times, oversized phase and delay counts, and a dead time above the half-period. A design that skips a clamp would show overlapping complementary gates, or a rectifier that clears after it was set in the same half. Settings are changed at random positions under an irregular tick. A design that samples them outside the half boundary would move edges mid-half, and the per-step reference model flags this at once. Enable is dropped mid-period to confirm that everything clears on the next edge and restarts in the `lead_p` half. Default settings keep both rectifiers high at the start of each half and again after the lag point, so the interlock is exercised. A design without the interlock would let a primary gate stay high through that region.

// File: rtl/psfb_pkg.sv
// Shared types for the phase-shifted bridge sequencer.
package psfb_pkg;

    // Which leading-leg switch owns the current half-cycle
    typedef enum logic {
        HALF_LEAD  = 1'b0,
        HALF_TRAIL = 1'b1
    } half_e;

    // The six gate levels, primary pairs first
    typedef struct packed {
        logic lead_p;
        logic lead_n;
        logic lag_p;
        logic lag_n;
        logic rect_p;
        logic rect_n;
    } gates_t;

endpackage

// File: rtl/psfb_timebase.sv
// Half-cycle position counter.
// Counts steps 0..HALF_STEPS-1 within a half and toggles the half owner on wrap.
// Assumes step is a single-clock tick; en low parks the counter at the start.
module psfb_timebase
    import psfb_pkg::*;
#(
    parameter int unsigned HALF_STEPS = 32,
    parameter int unsigned CW         = $clog2(HALF_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    output half_e         half,
    output logic [CW-1:0] pos,
    output logic          first
);

    localparam logic [CW-1:0] LAST = CW'(HALF_STEPS - 1);

    // Advance position on each tick, swap half owner at wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pos  <= '0;
            half <= HALF_LEAD;
        end else if (step) begin
            if (pos == LAST) begin
                pos  <= '0;
                half <= (half == HALF_LEAD) ? HALF_TRAIL : HALF_LEAD;
            end else begin
                pos <= pos + CW'(1);
            end
        end
    end

    // First step of a half-cycle
    assign first = (pos == '0);

endmodule

// File: rtl/psfb_setpoints.sv
// Setting clamp and half-boundary capture.
// Clamps dead times to 1..HALF_STEPS-1, limits the lag offset so the lag
// turn-on lands inside the half, and limits the rectifier delay to one step
// before that turn-on. Values are captured on the first step of each half;
// during that step the live clamped values are used directly.
module psfb_setpoints #(
    parameter int unsigned HALF_STEPS = 32,
    parameter int unsigned CW         = $clog2(HALF_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  logic          first,
    input  logic [CW-1:0] dead_ab,
    input  logic [CW-1:0] dead_cd,
    input  logic [CW-1:0] phase_cmd,
    input  logic [CW-1:0] sr_delay,
    output logic [CW-1:0] lead_dead,
    output logic [CW-1:0] lag_off,
    output logic [CW-1:0] lag_on,
    output logic [CW-1:0] rect_off
);

    localparam logic [CW-1:0] MAXD = CW'(HALF_STEPS - 1);

    function automatic logic [CW-1:0] clamp_dead(input logic [CW-1:0] x);
        if (x == '0)  return CW'(1);
        if (x > MAXD) return MAXD;
        return x;
    endfunction

    logic [CW-1:0] ab_c, cd_c, ps_lim, ps_c, on_c, sr_lim, sr_c;
    logic [CW-1:0] ab_q, off_q, on_q, sr_q;

    // Clamp the live inputs into a safe, ordered set
    always_comb begin
        ab_c   = clamp_dead(dead_ab);
        cd_c   = clamp_dead(dead_cd);
        ps_lim = MAXD - cd_c;
        ps_c   = (phase_cmd > ps_lim) ? ps_lim : phase_cmd;
        on_c   = ps_c + cd_c;
        sr_lim = on_c - CW'(1);
        sr_c   = (sr_delay > sr_lim) ? sr_lim : sr_delay;
    end

    // Capture clamped settings at the start of every half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_q  <= CW'(1);
            off_q <= '0;
            on_q  <= CW'(1);
            sr_q  <= '0;
        end else if (en && step && first) begin
            ab_q  <= ab_c;
            off_q <= ps_c;
            on_q  <= on_c;
            sr_q  <= sr_c;
        end
    end

    assign lead_dead = first ? ab_c : ab_q;
    assign lag_off   = first ? ps_c : off_q;
    assign lag_on    = first ? on_c : on_q;
    assign rect_off  = first ? sr_c : sr_q;

endmodule

// File: rtl/psfb_drive.sv
// Gate output stage.
// Applies the per-half switching events to registered gate levels: lagging
// leg and rectifier edges as set/clear events, leading leg as a window decode.
// The interlock is evaluated on the next rectifier levels, so a primary gate
// can never be registered high alongside two high rectifier gates.
module psfb_drive
    import psfb_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  half_e         half,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] lead_dead,
    input  logic [CW-1:0] lag_off,
    input  logic [CW-1:0] lag_on,
    input  logic [CW-1:0] rect_off,
    output gates_t        gates
);

    gates_t nxt;
    logic   rect_both;

    // Next gate levels for the current step position
    always_comb begin
        nxt = gates;
        if (half == HALF_LEAD) begin
            if (pos == lag_off)  nxt.lag_n  = 1'b0;
            if (pos == rect_off) nxt.rect_p = 1'b0;
            if (pos == lag_on) begin
                nxt.lag_p  = 1'b1;
                nxt.rect_p = 1'b1;
            end
        end else begin
            if (pos == lag_off)  nxt.lag_p  = 1'b0;
            if (pos == rect_off) nxt.rect_n = 1'b0;
            if (pos == lag_on) begin
                nxt.lag_n  = 1'b1;
                nxt.rect_n = 1'b1;
            end
        end
        rect_both  = nxt.rect_p && nxt.rect_n;
        nxt.lead_p = (half == HALF_LEAD)  && (pos >= lead_dead) && !rect_both;
        nxt.lead_n = (half == HALF_TRAIL) && (pos >= lead_dead) && !rect_both;
    end

    // Register gate levels; disable clears them on the next edge
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            gates <= '0;
        end else if (step) begin
            gates <= nxt;
        end
    end

endmodule

// File: rtl/psfb_gate_seq.sv
// Phase-shifted full-bridge gate sequencer, top level.
// Ties the half-cycle timebase, the setting clamp/capture and the gate stage
// together. Assumes all setting inputs are synchronous to clk.
module psfb_gate_seq
    import psfb_pkg::*;
#(
    parameter  int unsigned HALF_STEPS = 32,
    localparam int unsigned CW         = $clog2(HALF_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  logic [CW-1:0] phase_cmd,
    input  logic [CW-1:0] dead_ab,
    input  logic [CW-1:0] dead_cd,
    input  logic [CW-1:0] sr_delay,
    output logic          lead_p,
    output logic          lead_n,
    output logic          lag_p,
    output logic          lag_n,
    output logic          rect_p,
    output logic          rect_n
);

    half_e         half;
    logic [CW-1:0] pos;
    logic          first;
    logic [CW-1:0] lead_dead, lag_off, lag_on, rect_off;
    gates_t        gates;

    psfb_timebase #(.HALF_STEPS(HALF_STEPS), .CW(CW)) u_timebase (
        .clk(clk), .rst_n(rst_n), .en(en), .step(step),
        .half(half), .pos(pos), .first(first)
    );

    psfb_setpoints #(.HALF_STEPS(HALF_STEPS), .CW(CW)) u_setpoints (
        .clk(clk), .rst_n(rst_n), .en(en), .step(step), .first(first),
        .dead_ab(dead_ab), .dead_cd(dead_cd), .phase_cmd(phase_cmd),
        .sr_delay(sr_delay),
        .lead_dead(lead_dead), .lag_off(lag_off), .lag_on(lag_on),
        .rect_off(rect_off)
    );

    psfb_drive #(.CW(CW)) u_drive (
        .clk(clk), .rst_n(rst_n), .en(en), .step(step),
        .half(half), .pos(pos),
        .lead_dead(lead_dead), .lag_off(lag_off), .lag_on(lag_on),
        .rect_off(rect_off), .gates(gates)
    );

    assign lead_p = gates.lead_p;
    assign lead_n = gates.lead_n;
    assign lag_p  = gates.lag_p;
    assign lag_n  = gates.lag_n;
    assign rect_p = gates.rect_p;
    assign rect_n = gates.rect_n;

endmodule

// File: rtl/psfb_gate_seq_chk.sv
// Protocol checker for the gate sequencer, bound onto the top module.
// Observes ports only.
module psfb_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic step,
    input logic lp,
    input logic ln,
    input logic cp,
    input logic cn,
    input logic rp,
    input logic rn
);

    // R1
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(lp || ln || cp || cn || rp || rn));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> ($stable(lp) && $stable(ln) && $stable(cp) &&
                           $stable(cn) && $stable(rp) && $stable(rn)));

    // R3
    lead_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp && ln));

    // R3
    lead_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lp) || $rose(ln)) |-> (!$past(lp) && !$past(ln)));

    // R4
    lag_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp && cn));

    // R4
    lag_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cp) || $rose(cn)) |-> (!$past(cp) && !$past(cn)));

    // R6
    rect_p_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp) |-> $rose(rp));

    // R6
    rect_n_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cn) |-> $rose(rn));

    // R8
    interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp && rn) |-> !(lp || ln));

endmodule

bind psfb_gate_seq psfb_gate_seq_chk u_psfb_gate_seq_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .lp(lead_p), .ln(lead_n), .cp(lag_p), .cn(lag_n),
    .rp(rect_p), .rn(rect_n)
);

// File: tb/test_psfb_gate_seq.sv
module test_psfb_gate_seq;

    localparam int HALF = 32;
    localparam int CW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic step = 1'b0;
    logic [CW-1:0] phase_cmd = '0, dead_ab = '0, dead_cd = '0, sr_delay = '0;
    logic lead_p, lead_n, lag_p, lag_n, rect_p, rect_n;

    always #5 clk = ~clk;

    psfb_gate_seq #(.HALF_STEPS(HALF)) i_psfb_gate_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .step(step),
        .phase_cmd(phase_cmd), .dead_ab(dead_ab), .dead_cd(dead_cd),
        .sr_delay(sr_delay),
        .lead_p(lead_p), .lead_n(lead_n), .lag_p(lag_p), .lag_n(lag_n),
        .rect_p(rect_p), .rect_n(rect_n)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pos = 0, m_half = 0, steps = 0;
    int s_ab = 1, s_off = 0, s_on = 1, s_sr = 0;
    bit ma, mb, mc, md, me, mf;

    function automatic int lim_dead(input int x);
        if (x == 0) return 1;
        if (x > HALF - 1) return HALF - 1;
        return x;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || !en) begin
            {ma, mb, mc, md, me, mf} = '0;
            m_pos = 0;
            m_half = 0;
        end else if (step) begin
            if (m_pos == 0) begin
                int cd, lim;
                cd    = lim_dead(int'(dead_cd));
                s_ab  = lim_dead(int'(dead_ab));
                lim   = HALF - 1 - cd;
                s_off = (int'(phase_cmd) > lim) ? lim : int'(phase_cmd);
                s_on  = s_off + cd;
                s_sr  = (int'(sr_delay) > s_on - 1) ? s_on - 1 : int'(sr_delay);
            end
            if (m_half == 0) begin
                if (m_pos == s_off) md = 0;
                if (m_pos == s_sr)  me = 0;
                if (m_pos == s_on) begin mc = 1; me = 1; end
            end else begin
                if (m_pos == s_off) mc = 0;
                if (m_pos == s_sr)  mf = 0;
                if (m_pos == s_on) begin md = 1; mf = 1; end
            end
            ma = (m_half == 0) && (m_pos >= s_ab) && !(me && mf);
            mb = (m_half == 1) && (m_pos >= s_ab) && !(me && mf);
            steps++;
            m_pos++;
            if (m_pos == HALF) begin
                m_pos = 0;
                m_half ^= 1;
            end
        end
    end

    // ---------------- monitor, sampled at the falling edge ----------------
    string tag = "R1";
    bit cmp_on = 0, period_on = 0;
    int last_a = -1;
    int interlock_bad = 0, overlap_bad = 0, rise_bad = 0;
    logic [5:0] prev_g = '0;

    always @(negedge clk) begin
        logic [5:0] g, m;
        g = {lead_p, lead_n, lag_p, lag_n, rect_p, rect_n};
        m = {ma, mb, mc, md, me, mf};
        if (cmp_on) check(g == m, tag, "gates vs model", int'(g), int'(m));
        if ((g[5] || g[4]) && g[1] && g[0]) interlock_bad++;
        if ((g[5] && g[4]) || (g[3] && g[2])) overlap_bad++;
        if ((g[3] && !prev_g[3]) && !(g[1] && !prev_g[1])) rise_bad++;
        if ((g[2] && !prev_g[2]) && !(g[0] && !prev_g[0])) rise_bad++;
        if (period_on && g[5] && !prev_g[5]) begin
            if (last_a >= 0)
                check(steps - last_a == 2 * HALF, "R2", "lead_p rise spacing",
                      steps - last_a, 2 * HALF);
            last_a = steps;
        end
        if (period_on && g[4] && !prev_g[4] && last_a >= 0)
            check(steps - last_a == HALF, "R9", "lead_p to lead_n rise",
                  steps - last_a, HALF);
        prev_g = g;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [5:0] held;
        int first_up;

        // R1: reset state
        repeat (3) @(negedge clk);
        check({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n} == 6'b0, "R1",
              "outputs in reset", int'({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n} == 6'b0, "R1",
              "outputs with en low", int'({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n}), 0);

        // Main function, constant settings, tick every clock
        phase_cmd = 6'd10; dead_ab = 6'd3; dead_cd = 6'd4; sr_delay = 6'd2;
        en = 1'b1; step = 1'b1;
        cmp_on = 1; period_on = 1;
        tag = "R3 R4 R6 R7 R8";
        repeat (300) @(negedge clk);
        period_on = 0;

        // R2: hold with no tick, R5: setting change while frozen has no effect
        step = 1'b0;
        held = {lead_p, lead_n, lag_p, lag_n, rect_p, rect_n};
        phase_cmd = 6'd1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n} == held, "R2",
                  "hold without step", int'({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n}),
                  int'(held));
        end
        phase_cmd = 6'd10;

        // Sparse tick
        tag = "R2 R5";
        for (int i = 0; i < 600; i++) begin
            step = (i % 3 == 0);
            @(negedge clk);
        end

        // Clamp corners
        tag = "R3 R4 R7 clamp";
        step = 1'b1;
        dead_ab = 6'd0; dead_cd = 6'd0; phase_cmd = 6'd63; sr_delay = 6'd63;
        repeat (200) @(negedge clk);
        dead_cd = 6'd40; phase_cmd = 6'd0; dead_ab = 6'd31; sr_delay = 6'd5;
        repeat (200) @(negedge clk);

        // Random settings at random positions, irregular tick
        tag = "R5 R8";
        for (int i = 0; i < 4000; i++) begin
            step = ($urandom % 2) == 1;
            if ($urandom % 6 == 0) begin
                phase_cmd = 6'($urandom_range(0, 40));
                dead_ab   = 6'($urandom_range(0, 40));
                dead_cd   = 6'($urandom_range(0, 40));
                sr_delay  = 6'($urandom_range(0, 40));
            end
            @(negedge clk);
        end

        // R1: disable mid-run, then restart in the lead_p half
        tag = "R1";
        step = 1'b1;
        phase_cmd = 6'd10; dead_ab = 6'd3; dead_cd = 6'd4; sr_delay = 6'd2;
        repeat (45) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n} == 6'b0, "R1",
              "outputs after disable", int'({lead_p, lead_n, lag_p, lag_n, rect_p, rect_n}), 0);
        en = 1'b1;
        first_up = 0;
        for (int i = 0; i < 2 * HALF; i++) begin
            @(negedge clk);
            if (first_up == 0 && lead_p) first_up = 1;
            else if (first_up == 0 && lead_n) first_up = 2;
        end
        check(first_up == 1, "R1", "first primary after restart (1=lead_p)", first_up, 1);

        cmp_on = 0;
        check(interlock_bad == 0, "R8", "primary high with both rectifiers", interlock_bad, 0);
        check(overlap_bad == 0, "R3", "complementary overlap steps", overlap_bad, 0);
        check(rise_bad == 0, "R6", "lag rise without rectifier rise", rise_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule